// File: doc/BRIEF.md
# Accumulator ALU with flag generation

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each cycle it takes an opcode, the accumulator byte, a second operand byte, an auxiliary B byte and the current carry, auxiliary-carry and overflow flags. From these it computes a new result byte, a new B byte and a new flag set. All outputs are registered, so the outcome of an operation presented before a rising edge appears right after that edge.

The operations cover three groups. The arithmetic group has add, add with carry, subtract with borrow, increment and decrement. The paired-register group has multiply and divide, which use the accumulator and B together, plus decimal adjust after a packed-BCD add. The bit group has AND, OR, XOR, clear, complement, nibble swap and four rotates. A flag that an operation does not define is copied unchanged from its input. The parity output is always recomputed from the result byte. Instruction fetch, operand addressing and register storage are handled by the surrounding machine.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, every registered output (res_q, b_q, cy_q, ac_q, ov_q, par_q) is 0.
- R2: Add (op 0) and add with carry (op 1, which also adds cy_in) write res_q = sum mod 256. cy_q is the carry out of bit 7 and ac_q is the carry out of bit 3. ov_q is 1 exactly when the signed sum lies outside -128..127. b_q equals b_in.
- R3: Subtract with borrow (op 2) writes res_q = (acc - opnd - cy_in) mod 256. cy_q is 1 when the unsigned difference is negative, and ac_q is 1 when the low-nibble difference is negative. ov_q is 1 when the signed difference lies outside -128..127. b_q equals b_in.
- R4: Multiply (op 3) writes the low byte of acc*b_in to res_q and the high byte to b_q. It clears cy_q, sets ov_q exactly when the high byte is nonzero, and passes ac_in through.
- R5: Divide (op 4) writes the quotient acc/b_in to res_q and the remainder to b_q, with cy_q = 0 and ov_q = 0. When b_in is 0 it writes res_q = 0xFF, b_q = acc, ov_q = 1 and cy_q = 0. ac_in passes through in both cases.
- R6: Decimal adjust (op 5) first adds 0x06 when the low nibble exceeds 9 or ac_in is 1. It then adds 0x60 when the high nibble of that intermediate value exceeds 9 or the carry so far is 1. The carry so far starts from cy_in and is set by a carry out of either step. cy_q is that carry, so it is never cleared. ac_q and ov_q pass through.
- R7: AND, OR, XOR with opnd (ops 6, 7, 8), clear to 0 (op 9), bitwise complement (op 10) and nibble swap (op 11) change only the result. cy_q, ac_q and ov_q equal their inputs, and b_q equals b_in.
- R8: Rotate left (op 12) and rotate right (op 13) move the accumulator one bit round in 8 bits and leave cy_q = cy_in. Rotate left through carry (op 14) and rotate right through carry (op 15) form a 9-bit ring with the carry. For op 14, res_q[0] = cy_in and cy_q = acc[7]. For op 15, res_q[7] = cy_in and cy_q = acc[0].
- R9: Increment (op 16) and decrement (op 17) write (acc ± 1) mod 256 and leave cy_q, ac_q and ov_q equal to their inputs.
- R10: par_q is 1 exactly when res_q holds an odd number of ones, for every operation.
- R11: Opcodes 18 to 31 write res_q = acc and pass b_in and all input flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 5 | Operation select |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| b_in | input | 8 | Auxiliary B byte |
| cy_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary-carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| res_q | output | 8 | Registered result byte |
| b_q | output | 8 | Registered B byte |
| cy_q | output | 1 | Registered carry flag |
| ac_q | output | 1 | Registered auxiliary-carry flag |
| ov_q | output | 1 | Registered overflow flag |
| par_q | output | 1 | Registered parity of res_q |

## Verification
Add and subtract are swept over every accumulator value against a stride of operands, with both carry-in values. Overflow is recomputed from signed integer range, so a design that took the bit-6 carry from the wrong place would flip ov_q on about a quarter of the vectors. Divide by zero is hit for every accumulator value, and a design that left the quotient undefined or reported the original B there would mismatch at once. Decimal adjust is run over all bytes under all four combinations of incoming carry and auxiliary carry. This exposes a design that clears the carry or tests the high nibble before the low correction. The pass-through cases for rotates, increment and the unused codes use set input flags, so a design that zeroes a flag it should not touch is caught.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] op,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic [7:0] b_in,
  input  logic       cy_in,
  input  logic       ac_in,
  input  logic       ov_in,
  output logic [7:0] res_q,
  output logic [7:0] b_q,
  output logic       cy_q,
  output logic       ac_q,
  output logic       ov_q,
  output logic       par_q
);
  localparam logic [4:0] OP_ADD = 5'd0, OP_ADDC = 5'd1, OP_SUBB = 5'd2, OP_MUL = 5'd3;
  localparam logic [4:0] OP_DIV = 5'd4, OP_DA = 5'd5, OP_AND = 5'd6, OP_OR = 5'd7;
  localparam logic [4:0] OP_XOR = 5'd8, OP_CLR = 5'd9, OP_CPL = 5'd10, OP_SWAP = 5'd11;
  localparam logic [4:0] OP_RL = 5'd12, OP_RR = 5'd13, OP_RLC = 5'd14, OP_RRC = 5'd15;
  localparam logic [4:0] OP_INC = 5'd16, OP_DEC = 5'd17;

  logic       ci;
  logic [8:0] add9, sub9;
  logic [4:0] add_lo, sub_lo;
  logic [7:0] add_mid, sub_mid;
  logic [15:0] prod;
  logic       dz;
  logic [7:0] quo, rem;
  logic       da_lo_fix, da_hi_fix;
  logic [8:0] da1, da2;
  logic       da_c1;

  assign ci      = (op == OP_ADDC || op == OP_SUBB) ? cy_in : 1'b0;
  assign add9    = {1'b0, acc_in} + {1'b0, opnd_in} + {8'd0, ci};
  assign add_lo  = {1'b0, acc_in[3:0]} + {1'b0, opnd_in[3:0]} + {4'd0, ci};
  assign add_mid = {1'b0, acc_in[6:0]} + {1'b0, opnd_in[6:0]} + {7'd0, ci};
  assign sub9    = {1'b0, acc_in} - {1'b0, opnd_in} - {8'd0, ci};
  assign sub_lo  = {1'b0, acc_in[3:0]} - {1'b0, opnd_in[3:0]} - {4'd0, ci};
  assign sub_mid = {1'b0, acc_in[6:0]} - {1'b0, opnd_in[6:0]} - {7'd0, ci};

  assign prod = acc_in * b_in;
  assign dz   = (b_in == 8'd0);
  assign quo  = dz ? 8'hFF : acc_in / b_in;
  assign rem  = dz ? acc_in : acc_in % b_in;

  assign da_lo_fix = (acc_in[3:0] > 4'd9) || ac_in;
  assign da1       = {1'b0, acc_in} + (da_lo_fix ? 9'h006 : 9'h000);
  assign da_c1     = cy_in | da1[8];
  assign da_hi_fix = (da1[7:4] > 4'd9) || da_c1;
  assign da2       = {1'b0, da1[7:0]} + (da_hi_fix ? 9'h060 : 9'h000);

  logic [7:0] n_res, n_b;
  logic       n_cy, n_ac, n_ov;

  always_comb begin
    n_res = acc_in;
    n_b   = b_in;
    n_cy  = cy_in;
    n_ac  = ac_in;
    n_ov  = ov_in;
    case (op)
      OP_ADD, OP_ADDC: begin
        n_res = add9[7:0];
        n_cy  = add9[8];
        n_ac  = add_lo[4];
        n_ov  = add9[8] ^ add_mid[7];
      end
      OP_SUBB: begin
        n_res = sub9[7:0];
        n_cy  = sub9[8];
        n_ac  = sub_lo[4];
        n_ov  = sub9[8] ^ sub_mid[7];
      end
      OP_MUL: begin
        n_res = prod[7:0];
        n_b   = prod[15:8];
        n_cy  = 1'b0;
        n_ov  = |prod[15:8];
      end
      OP_DIV: begin
        n_res = quo;
        n_b   = rem;
        n_cy  = 1'b0;
        n_ov  = dz;
      end
      OP_DA: begin
        n_res = da2[7:0];
        n_cy  = da_c1 | da2[8];
      end
      OP_AND:  n_res = acc_in & opnd_in;
      OP_OR:   n_res = acc_in | opnd_in;
      OP_XOR:  n_res = acc_in ^ opnd_in;
      OP_CLR:  n_res = 8'h00;
      OP_CPL:  n_res = ~acc_in;
      OP_SWAP: n_res = {acc_in[3:0], acc_in[7:4]};
      OP_RL:   n_res = {acc_in[6:0], acc_in[7]};
      OP_RR:   n_res = {acc_in[0], acc_in[7:1]};
      OP_RLC: begin
        n_res = {acc_in[6:0], cy_in};
        n_cy  = acc_in[7];
      end
      OP_RRC: begin
        n_res = {cy_in, acc_in[7:1]};
        n_cy  = acc_in[0];
      end
      OP_INC:  n_res = acc_in + 8'd1;
      OP_DEC:  n_res = acc_in - 8'd1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= 8'h00;
      b_q   <= 8'h00;
      cy_q  <= 1'b0;
      ac_q  <= 1'b0;
      ov_q  <= 1'b0;
      par_q <= 1'b0;
    end else begin
      res_q <= n_res;
      b_q   <= n_b;
      cy_q  <= n_cy;
      ac_q  <= n_ac;
      ov_q  <= n_ov;
      par_q <= ^n_res;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] op,
  input logic [7:0] acc_in,
  input logic [7:0] b_in,
  input logic       cy_in,
  input logic       ac_in,
  input logic       ov_in,
  input logic [7:0] res_q,
  input logic [7:0] b_q,
  input logic       cy_q,
  input logic       ac_q,
  input logic       ov_q,
  input logic       par_q
);
  localparam logic [4:0] C_MUL = 5'd3, C_DIV = 5'd4, C_SWAP = 5'd11, C_RLC = 5'd14;
  localparam logic [4:0] C_INC = 5'd16, C_DEC = 5'd17;

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (res_q == 8'h00 && b_q == 8'h00 && !cy_q && !ac_q && !ov_q && !par_q);
    end
  end

  a_r10_parity: assert property (@(posedge clk) disable iff (!rst_n)
    par_q == ^res_q);

  a_r4_mul_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op == C_MUL) |=> (!cy_q && ov_q == (b_q != 8'h00) && ac_q == $past(ac_in)));

  a_r5_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op == C_DIV && b_in == 8'h00) |=> (ov_q && !cy_q && res_q == 8'hFF && b_q == $past(acc_in)));

  a_r7_swap_nibbles: assert property (@(posedge clk) disable iff (!rst_n)
    (op == C_SWAP) |=> (res_q == {$past(acc_in[3:0]), $past(acc_in[7:4])} && cy_q == $past(cy_in)));

  a_r8_rlc_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (op == C_RLC) |=> (cy_q == $past(acc_in[7]) && res_q[0] == $past(cy_in)));

  a_r9_incdec_keep_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op == C_INC || op == C_DEC) |=> (cy_q == $past(cy_in) && ac_q == $past(ac_in) && ov_q == $past(ov_in)));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .acc_in(acc_in), .b_in(b_in),
  .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in), .res_q(res_q), .b_q(b_q),
  .cy_q(cy_q), .ac_q(ac_q), .ov_q(ov_q), .par_q(par_q)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] acc_in = 8'd0, opnd_in = 8'd0, b_in = 8'd0;
  logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
  logic [7:0] res_q, b_q;
  logic       cy_q, ac_q, ov_q, par_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst_n(rst_n), .op(op), .acc_in(acc_in), .opnd_in(opnd_in),
    .b_in(b_in), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .res_q(res_q), .b_q(b_q), .cy_q(cy_q), .ac_q(ac_q), .ov_q(ov_q), .par_q(par_q)
  );

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic logic [19:0] model(input int o, input int a, input int d, input int b,
                                        input int c, input int h, input int v);
    int r, bb, cy, ac, ov, s, t, ones;
    r = a; bb = b; cy = c; ac = h; ov = v;
    case (o)
      0, 1: begin
        s = a + d + ((o == 1) ? c : 0);
        r = s % 256; cy = (s > 255);
        ac = ((a % 16) + (d % 16) + ((o == 1) ? c : 0)) > 15;
        t = sgn(a) + sgn(d) + ((o == 1) ? c : 0);
        ov = (t > 127 || t < -128);
      end
      2: begin
        s = a - d - c;
        r = (s + 256) % 256; cy = (s < 0);
        ac = ((a % 16) - (d % 16) - c) < 0;
        t = sgn(a) - sgn(d) - c;
        ov = (t > 127 || t < -128);
      end
      3: begin
        s = a * b; r = s % 256; bb = s / 256; cy = 0; ov = (bb != 0);
      end
      4: begin
        cy = 0;
        if (b == 0) begin r = 255; bb = a; ov = 1; end
        else begin r = a / b; bb = a % b; ov = 0; end
      end
      5: begin
        t = a;
        if ((a % 16) > 9 || h == 1) t = t + 6;
        if (t > 255) cy = 1;
        t = t % 256;
        if ((t / 16) > 9 || cy == 1) t = t + 96;
        if (t > 255) cy = 1;
        r = t % 256;
      end
      6: r = a & d;
      7: r = a | d;
      8: r = a ^ d;
      9: r = 0;
      10: r = 255 - a;
      11: r = (a % 16) * 16 + a / 16;
      12: r = (a * 2) % 256 + a / 128;
      13: r = a / 2 + (a % 2) * 128;
      14: begin r = (a * 2) % 256 + c; cy = a / 128; end
      15: begin r = a / 2 + c * 128; cy = a % 2; end
      16: r = (a + 1) % 256;
      17: r = (a + 255) % 256;
      default: ;
    endcase
    ones = 0;
    for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
    return {r[7:0], bb[7:0], cy[0], ac[0], ov[0], ones[0]};
  endfunction

  task automatic run(input int o, input int a, input int d, input int b,
                     input int c, input int h, input int v, input string tag);
    logic [19:0] exp_v, got;
    op = o[4:0]; acc_in = a[7:0]; opnd_in = d[7:0]; b_in = b[7:0];
    cy_in = c[0]; ac_in = h[0]; ov_in = v[0];
    exp_v = model(o, a, d, b, c, h, v);
    @(negedge clk);
    got = {res_q, b_q, cy_q, ac_q, ov_q, par_q};
    n_chk++;
    if (got !== exp_v) begin
      n_bad++;
      if (n_bad <= 20)
        $display("FAIL %s op=%0d a=%02h d=%02h b=%02h c=%0d h=%0d v=%0d got res=%02h b=%02h cy/ac/ov/p=%b exp res=%02h b=%02h cy/ac/ov/p=%b",
                 tag, o, a, d, b, c, h, v, got[19:12], got[11:4], got[3:0],
                 exp_v[19:12], exp_v[11:4], exp_v[3:0]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got running expected finished");
    finish_run();
  end

  initial begin
    op = 5'd3; acc_in = 8'hFF; b_in = 8'hFF; cy_in = 1'b1; ac_in = 1'b1; ov_in = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if ({res_q, b_q, cy_q, ac_q, ov_q, par_q} !== 20'd0) begin
      n_bad++;
      $display("FAIL R1 reset got %h expected 0", {res_q, b_q, cy_q, ac_q, ov_q, par_q});
    end
    rst_n = 1'b1;

    // R2 and R3 with R10 parity on every vector
    for (int a = 0; a < 256; a++)
      for (int d = 0; d < 256; d += 7)
        for (int c = 0; c < 2; c++) begin
          run(0, a, d, a ^ 8'h5A, c, 1 - c, c, "R2");
          run(1, a, d, 8'h33, c, c, 1 - c, "R2");
          run(2, a, d, 8'hC3, c, 1 - c, c, "R3");
        end
    run(0, 8'h7F, 8'h01, 0, 0, 0, 0, "R2");
    run(1, 8'hFF, 8'h00, 0, 1, 0, 0, "R2");
    run(2, 8'h80, 8'h01, 0, 0, 0, 0, "R3");
    run(2, 8'h00, 8'h00, 0, 1, 0, 0, "R3");

    // R4 multiply
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 5) run(3, a, a, b, a % 2, b % 2, 1, "R4");
    run(3, 255, 0, 255, 1, 1, 0, "R4");
    run(3, 15, 0, 17, 1, 0, 1, "R4");

    // R5 divide, zero divisor every accumulator value
    for (int a = 0; a < 256; a++) begin
      run(4, a, 0, 0, 1, a % 2, 0, "R5");
      for (int b = 1; b < 256; b += 19) run(4, a, 0, b, 1, 1, 1, "R5");
    end

    // R6 decimal adjust
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 4; f++) run(5, a, 0, 8'h11, f / 2, f % 2, f % 2, "R6");

    // R7 R8 R9 R11 sweeps with flags set and cleared
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 2; f++) begin
        run(6,  a, 255 - a / 2, 8'h21, f, f, f, "R7");
        run(7,  a, a * 3 % 256, 8'h21, f, f, f, "R7");
        run(8,  a, 8'hA5, 8'h21, f, 1 - f, f, "R7");
        run(9,  a, 0, 8'h21, f, f, 1 - f, "R7");
        run(10, a, 0, 8'h21, f, f, f, "R7");
        run(11, a, 0, 8'h21, 1 - f, f, f, "R7");
        run(12, a, 0, 8'h44, f, f, f, "R8");
        run(13, a, 0, 8'h44, f, 1 - f, f, "R8");
        run(14, a, 0, 8'h44, f, f, 1 - f, "R8");
        run(15, a, 0, 8'h44, f, f, f, "R8");
        run(16, a, 0, 8'h99, f, f, f, "R9");
        run(17, a, 0, 8'h99, f, 1 - f, f, "R9");
        run(18, a, 7, 8'h66, f, f, f, "R11");
        run(31, a, 7, 8'h66, 1 - f, f, 1 - f, "R11");
      end
    run(16, 255, 0, 0, 1, 1, 1, "R9");
    run(17, 0, 0, 0, 0, 0, 0, "R9");
    run(0, 8'h01, 8'h02, 0, 0, 0, 0, "R10");
    run(25, 8'hC3, 0, 8'h3C, 1, 0, 1, "R11");

    finish_run();
  end
endmodule